// File: doc/BRIEF.md
# Flash Page Write Sequencer

This controller lets software program flash in blocks of eight bytes. Software first loads a table pointer. It then writes each data byte to a byte latch and issues a table-write strobe. The strobe copies the latch into the holding register that the pointer's low three bits select, and can also advance the pointer by one. Table writes only fill the holding buffer. They never touch the flash.

To commit the buffer, software writes the two-step key (55h, then AAh) to the key register. It then writes the control register with program-memory select set, configuration select clear, write-enable set and the start bit set. The block then holds the CPU in a stall for a fixed number of clock cycles. On the last stalled cycle it emits one page-write pulse carrying the 8-byte-aligned target address and all eight buffered bytes. It then clears the start bit and presets the holding buffer to FFh. A 64-byte row is rewritten as eight such commits.

Top module: `flash_page_writer`

## Requirements
- R1: After reset the control readback is 00h, the pointer readback is 0, and both stall and the page-write pulse are low.
- R2: A table-write strobe stores the byte latch (register address 0) into the holding byte indexed by pointer bits [2:0]. When the increment input is high, the pointer advances by one in the same cycle. Table writes never produce a page-write pulse.
- R3: A commit writes all eight holding bytes at once. Byte i appears on page-data bits [8i+7:8i]. The target address is the table pointer, taken when the start is accepted, with its low three bits cleared.
- R4: A start is accepted only when the two previous register writes were 55h and then AAh to the key register (address 2), and the start comes in the next register write, which goes to the control register (address 1, start = bit 1).
- R5: A wrong key value, or any other register write between the key writes or between the key and the start, discards the unlock. The start that follows is then ignored: the start bit reads 0, stall stays low and no page write occurs.
- R6: A start is also ignored unless the control data has program-memory select (bit 7) = 1, configuration select (bit 6) = 0 and write-enable (bit 2) = 1. The other control bits are still stored and read back.
- R7: Stall rises in the cycle after an accepted start and stays high for exactly PROG_CYCLES cycles. The start bit reads 1 for that whole time and clears when stall falls. The page-write pulse occurs on the last stalled cycle.
- R8: After each commit, every holding byte reads as FFh, so bytes not written before the next commit are sent as FFh.
- R9: While stall is high, register writes, pointer loads and table writes are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 byte latch, 1 control, 2 key |
| reg_wdata | input | 8 | Register write data |
| ptr_ld | input | 1 | Load table pointer |
| ptr_val | input | AW | Pointer load value |
| tbl_wr | input | 1 | Table-write strobe |
| tbl_inc | input | 1 | Advance pointer on this table write |
| ctrl_rd | output | 8 | Control register readback |
| ptr_rd | output | AW | Table pointer readback |
| stall | output | 1 | CPU stall during the timed write |
| pg_we | output | 1 | One-cycle page-write pulse |
| pg_addr | output | AW | Aligned page-write address |
| pg_data | output | 8*HOLD_BYTES | Holding buffer contents |

## Verification
Every register, pointer and holding-buffer update is registered. Its result is therefore visible in the cycle after the clock edge that takes the write, and the bench reads it on the falling edge that follows. Stall is first visible on the falling edge after the accepted control write. The bench then counts falling edges with stall high and expects exactly PROG_CYCLES. The page-write pulse is captured on the rising edge of the last stalled cycle. Its address and data are compared once stall has dropped, and the flash model is read back at that point.

// File: rtl/fpw_pkg.sv
package fpw_pkg;
    typedef enum logic [1:0] {
        KEY_IDLE  = 2'd0,
        KEY_HALF  = 2'd1,
        KEY_ARMED = 2'd2
    } key_st_e;

    localparam logic [1:0] RA_LATCH = 2'd0;
    localparam logic [1:0] RA_CTRL  = 2'd1;
    localparam logic [1:0] RA_KEY   = 2'd2;

    localparam int CB_PGM   = 7;
    localparam int CB_CFG   = 6;
    localparam int CB_WEN   = 2;
    localparam int CB_START = 1;

    localparam logic [7:0] KEY_FIRST  = 8'h55;
    localparam logic [7:0] KEY_SECOND = 8'hAA;
endpackage

// File: rtl/fpw_unlock.sv
module fpw_unlock
    import fpw_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [1:0] wr_addr,
    input  logic [7:0] wr_data,
    output logic       armed
);
    key_st_e st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            if (wr_addr == RA_KEY) begin
                if (wr_data == KEY_FIRST)
                    st_d = KEY_HALF;
                else if (wr_data == KEY_SECOND && st_q == KEY_HALF)
                    st_d = KEY_ARMED;
                else
                    st_d = KEY_IDLE;
            end else begin
                st_d = KEY_IDLE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= KEY_IDLE;
        else        st_q <= st_d;
    end

    assign armed = (st_q == KEY_ARMED);

    // R4
    armed_after_second_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(armed) |-> $past(wr_en && wr_addr == RA_KEY && wr_data == KEY_SECOND));

    // R5
    write_disarms_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && wr_en) |=> !armed);
endmodule

// File: rtl/fpw_hold_buf.sv
module fpw_hold_buf #(
    parameter int NB = 8,
    localparam int IW = $clog2(NB)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [IW-1:0]   wr_idx,
    input  logic [7:0]      wr_byte,
    input  logic            clr,
    output logic [NB*8-1:0] data
);
    logic [7:0] bytes_d [NB];
    logic [7:0] bytes_q [NB];

    always_comb begin
        for (int i = 0; i < NB; i++) begin
            bytes_d[i] = bytes_q[i];
        end
        if (clr) begin
            for (int i = 0; i < NB; i++) begin
                bytes_d[i] = 8'hFF;
            end
        end else if (wr_en) begin
            bytes_d[wr_idx] = wr_byte;
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NB; i++) begin
            if (!rst_n) bytes_q[i] <= 8'hFF;
            else        bytes_q[i] <= bytes_d[i];
        end
    end

    for (genvar g = 0; g < NB; g++) begin : g_flat
        assign data[g*8 +: 8] = bytes_q[g];
    end

    // R8
    preset_after_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (data == {NB*8{1'b1}}));
endmodule

// File: rtl/fpw_prog_timer.sv
module fpw_prog_timer #(
    parameter int PROG_CYCLES = 500000,
    localparam int CW = $clog2(PROG_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    output logic busy,
    output logic done
);
    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (!s_q.busy) begin
            if (go) begin
                s_d.busy = 1'b1;
                s_d.cnt  = CW'(PROG_CYCLES);
            end
        end else if (s_q.cnt == CW'(1)) begin
            s_d.busy = 1'b0;
            s_d.cnt  = '0;
        end else begin
            s_d.cnt = s_q.cnt - CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy = s_q.busy;
    assign done = s_q.busy && (s_q.cnt == CW'(1));

    // R7
    stall_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    // R7
    stall_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
endmodule

// File: rtl/flash_page_writer.sv
module flash_page_writer
    import fpw_pkg::*;
#(
    parameter int AW          = 16,
    parameter int HOLD_BYTES  = 8,
    parameter int PROG_CYCLES = 500000,
    localparam int IW = $clog2(HOLD_BYTES),
    localparam int DW = HOLD_BYTES * 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [1:0]    reg_addr,
    input  logic [7:0]    reg_wdata,
    input  logic          ptr_ld,
    input  logic [AW-1:0] ptr_val,
    input  logic          tbl_wr,
    input  logic          tbl_inc,
    output logic [7:0]    ctrl_rd,
    output logic [AW-1:0] ptr_rd,
    output logic          stall,
    output logic          pg_we,
    output logic [AW-1:0] pg_addr,
    output logic [DW-1:0] pg_data
);
    localparam logic [AW-1:0] ALIGN_MASK = ~AW'(HOLD_BYTES - 1);

    typedef struct packed {
        logic [7:0]    latch;
        logic          pgm;
        logic          cfg;
        logic          wen;
        logic          start;
        logic [AW-1:0] ptr;
        logic [AW-1:0] cmt_addr;
    } st_t;

    st_t  s_d, s_q;
    logic busy, done, armed, go, bus_ok;

    assign bus_ok = !busy;

    fpw_unlock u_unlock (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr && bus_ok),
        .wr_addr (reg_addr),
        .wr_data (reg_wdata),
        .armed   (armed)
    );

    fpw_hold_buf #(.NB(HOLD_BYTES)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (tbl_wr && bus_ok),
        .wr_idx  (s_q.ptr[IW-1:0]),
        .wr_byte (s_q.latch),
        .clr     (done),
        .data    (pg_data)
    );

    fpw_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (go),
        .busy  (busy),
        .done  (done)
    );

    always_comb begin
        s_d = s_q;
        go  = 1'b0;
        if (bus_ok && reg_wr) begin
            case (reg_addr)
                RA_LATCH: s_d.latch = reg_wdata;
                RA_CTRL: begin
                    s_d.pgm = reg_wdata[CB_PGM];
                    s_d.cfg = reg_wdata[CB_CFG];
                    s_d.wen = reg_wdata[CB_WEN];
                    if (reg_wdata[CB_START] && armed && reg_wdata[CB_PGM]
                        && !reg_wdata[CB_CFG] && reg_wdata[CB_WEN]) begin
                        s_d.start    = 1'b1;
                        s_d.cmt_addr = s_q.ptr & ALIGN_MASK;
                        go           = 1'b1;
                    end
                end
                default: ;
            endcase
        end
        if (bus_ok && ptr_ld)
            s_d.ptr = ptr_val;
        else if (bus_ok && tbl_wr && tbl_inc)
            s_d.ptr = s_q.ptr + AW'(1);
        if (done)
            s_d.start = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ctrl_rd = {s_q.pgm, s_q.cfg, 3'b000, s_q.wen, s_q.start, 1'b0};
    assign ptr_rd  = s_q.ptr;
    assign stall   = busy;
    assign pg_we   = done;
    assign pg_addr = s_q.cmt_addr;

    // R3
    commit_within_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pg_we |-> (s_q.start && stall));

    // R4
    start_needs_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stall) |-> $past(armed && reg_wr && reg_addr == RA_CTRL));

    // R9
    busy_latch_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && reg_wr) |=> $stable(s_q.latch));

    // R9
    busy_ptr_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && (ptr_ld || tbl_wr)) |=> $stable(ptr_rd));

    // R7
    start_matches_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> ctrl_rd[CB_START]);
endmodule

// File: tb/flash_page_writer_tb.sv
module flash_page_writer_tb_top;
    localparam int AW   = 8;
    localparam int NB   = 8;
    localparam int PROG = 24;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          reg_wr, ptr_ld, tbl_wr, tbl_inc;
    logic [1:0]    reg_addr;
    logic [7:0]    reg_wdata;
    logic [AW-1:0] ptr_val;
    logic [7:0]    ctrl_rd;
    logic [AW-1:0] ptr_rd, pg_addr;
    logic          stall, pg_we;
    logic [NB*8-1:0] pg_data;

    int checks = 0;
    int errors = 0;
    int commits = 0;
    int wdog = 0;
    bit done_flag = 1'b0;
    logic [AW-1:0]   last_addr;
    logic [NB*8-1:0] last_data;
    logic [7:0] mem [256];

    always #2 clk = ~clk;

    flash_page_writer #(.AW(AW), .HOLD_BYTES(NB), .PROG_CYCLES(PROG)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .ptr_ld(ptr_ld), .ptr_val(ptr_val),
        .tbl_wr(tbl_wr), .tbl_inc(tbl_inc), .ctrl_rd(ctrl_rd), .ptr_rd(ptr_rd),
        .stall(stall), .pg_we(pg_we), .pg_addr(pg_addr), .pg_data(pg_data)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= 8'hFF;
        end else if (pg_we) begin
            commits   <= commits + 1;
            last_addr <= pg_addr;
            last_data <= pg_data;
            for (int i = 0; i < NB; i++)
                mem[8'(pg_addr + AW'(i))] <= mem[8'(pg_addr + AW'(i))] & pg_data[i*8 +: 8];
        end
    end

    always @(posedge clk) begin
        wdog <= wdog + 1;
        if (wdog > 100000 && !done_flag) begin
            done_flag = 1'b1;
            errors = errors + 1;
            $display("FAIL watchdog actual=%0d expected=%0d", wdog, 100000);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic ldptr(input logic [AW-1:0] v);
        @(negedge clk);
        ptr_ld = 1'b1; ptr_val = v;
        @(negedge clk);
        ptr_ld = 1'b0;
    endtask

    task automatic tbl(input logic [7:0] b, input bit inc);
        wr(2'd0, b);
        tbl_wr = 1'b1; tbl_inc = inc;
        @(negedge clk);
        tbl_wr = 1'b0; tbl_inc = 1'b0;
    endtask

    task automatic unlock();
        wr(2'd2, 8'h55);
        wr(2'd2, 8'hAA);
    endtask

    task automatic drain(output int n);
        n = 0;
        while (stall && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic load_block(input logic [AW-1:0] base, input logic [7:0] seed,
                              output logic [63:0] exp);
        ldptr(base);
        for (int i = 0; i < NB; i++) begin
            tbl(seed + 8'(i * 7), i != NB - 1);
            exp[i*8 +: 8] = seed + 8'(i * 7);
        end
    endtask

    task automatic t_reset();
        chk(ctrl_rd == 8'h00, "R1 ctrl", 64'(ctrl_rd), 64'h0);
        chk(ptr_rd == '0, "R1 ptr", 64'(ptr_rd), 64'h0);
        chk(!stall && !pg_we, "R1 stall/pg_we", {stall, pg_we}, 64'h0);
    endtask

    task automatic t_table();
        int c0;
        c0 = commits;
        ldptr(8'h23);
        tbl(8'h11, 1'b1);
        tbl(8'h22, 1'b1);
        tbl(8'h33, 1'b0);
        chk(ptr_rd == 8'h25, "R2 pointer advance", 64'(ptr_rd), 64'h25);
        repeat (3) @(negedge clk);
        chk(commits == c0 && !stall, "R2 no write from table", 64'(commits), 64'(c0));
    endtask

    task automatic t_commit();
        logic [63:0] exp;
        int n, c0;
        c0 = commits;
        load_block(8'h40, 8'h10, exp);
        chk(ptr_rd == 8'h47, "R2 pointer after block", 64'(ptr_rd), 64'h47);
        unlock();
        wr(2'd1, 8'h86);
        chk(stall == 1'b1, "R4 accepted start stalls", 64'(stall), 64'h1);
        chk(ctrl_rd == 8'h86, "R7 start bit set", 64'(ctrl_rd), 64'h86);
        drain(n);
        chk(n == PROG, "R7 stall length", 64'(n), 64'(PROG));
        chk(ctrl_rd == 8'h84, "R7 start bit cleared", 64'(ctrl_rd), 64'h84);
        chk(commits == c0 + 1, "R3 single commit", 64'(commits), 64'(c0 + 1));
        chk(last_addr == 8'h40, "R3 aligned address", 64'(last_addr), 64'h40);
        chk(last_data == exp, "R3 page data", last_data, exp);
    endtask

    task automatic t_preset();
        logic [63:0] exp;
        int n;
        exp = '1;
        exp[15:8] = 8'hAB;
        ldptr(8'h51);
        tbl(8'hAB, 1'b0);
        unlock();
        wr(2'd1, 8'h86);
        drain(n);
        chk(last_addr == 8'h50, "R3 unaligned pointer aligned", 64'(last_addr), 64'h50);
        chk(last_data == exp, "R8 unwritten bytes FF", last_data, exp);
    endtask

    task automatic t_bad_key();
        int c0;
        c0 = commits;
        wr(2'd2, 8'h55);
        wr(2'd2, 8'h12);
        wr(2'd1, 8'h86);
        chk(!stall && ctrl_rd == 8'h84, "R5 wrong key", {stall, ctrl_rd}, 64'h084);
        wr(2'd2, 8'h55);
        wr(2'd0, 8'h77);
        wr(2'd2, 8'hAA);
        wr(2'd1, 8'h86);
        chk(!stall && ctrl_rd == 8'h84, "R5 write between keys", {stall, ctrl_rd}, 64'h084);
        unlock();
        wr(2'd0, 8'h77);
        wr(2'd1, 8'h86);
        chk(!stall && ctrl_rd == 8'h84, "R5 write before start", {stall, ctrl_rd}, 64'h084);
        repeat (PROG + 4) @(negedge clk);
        chk(commits == c0, "R5 no page write", 64'(commits), 64'(c0));
    endtask

    task automatic t_ctrl_bits();
        int c0;
        c0 = commits;
        unlock();
        wr(2'd1, 8'h82);
        chk(!stall && ctrl_rd == 8'h82 - 8'h02, "R6 write-enable clear", {stall, ctrl_rd}, 64'h080);
        unlock();
        wr(2'd1, 8'hC6);
        chk(!stall && ctrl_rd == 8'hC4, "R6 config select set", {stall, ctrl_rd}, 64'h0C4);
        unlock();
        wr(2'd1, 8'h06);
        chk(!stall && ctrl_rd == 8'h04, "R6 program select clear", {stall, ctrl_rd}, 64'h004);
        repeat (PROG + 4) @(negedge clk);
        chk(commits == c0, "R6 no page write", 64'(commits), 64'(c0));
    endtask

    task automatic t_busy_ignore();
        int n;
        ldptr(8'h60);
        unlock();
        wr(2'd1, 8'h86);
        wr(2'd1, 8'h00);
        chk(ctrl_rd == 8'h86, "R9 control frozen", 64'(ctrl_rd), 64'h86);
        ldptr(8'h13);
        tbl_wr = 1'b1; tbl_inc = 1'b1;
        @(negedge clk);
        tbl_wr = 1'b0; tbl_inc = 1'b0;
        chk(ptr_rd == 8'h60, "R9 pointer frozen", 64'(ptr_rd), 64'h60);
        drain(n);
        chk(last_addr == 8'h60 && last_data == '1, "R9 commit unaffected", last_data, 64'hFFFF_FFFF_FFFF_FFFF);
    endtask

    task automatic t_row();
        logic [63:0] exp;
        int n, bad;
        bad = 0;
        for (int b = 0; b < 8; b++) begin
            load_block(8'h80 + 8'(b * 8), 8'(b * 16 + 3), exp);
            unlock();
            wr(2'd1, 8'h86);
            drain(n);
        end
        for (int b = 0; b < 8; b++) begin
            for (int i = 0; i < NB; i++) begin
                if (mem[8'h80 + 8'(b * 8 + i)] != 8'(b * 16 + 3) + 8'(i * 7)) bad++;
            end
        end
        chk(bad == 0, "R3 full row of eight commits", 64'(bad), 64'h0);
    endtask

    initial begin
        rst_n = 1'b0;
        reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
        ptr_ld = 1'b0; ptr_val = '0; tbl_wr = 1'b0; tbl_inc = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_table();
        t_commit();
        t_preset();
        t_bad_key();
        t_ctrl_bits();
        t_busy_ignore();
        t_row();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule